// File: doc/BRIEF.md
# Word Stack Engine

This block keeps a descending stack of 16-bit words in byte-wide memory. The stack pointer is a 16-bit offset inside a segment, and the segment value is shifted left by four bits to form the base. A push command stores one word and a pop command returns one. Every word travels as two byte transfers on a simple memory port. A caller that saves and restores a return location can issue these commands back to back, one for each word.

Before a push writes anything, the pointer drops by two. The word is then written low byte first: the low byte goes to the lower address and the high byte to the next address up. A pop reads the two bytes in the same order and waits for each byte to come back before it goes on. It hands the assembled word out with a one-cycle completion strobe and raises the pointer by two in the same step. The block is busy until each two-byte transfer finishes, and it ignores any command that arrives while it is busy.

Top module: `wstack_unit`

## Requirements
- R1: After reset the pointer output reads FFFEh, and busy, done and error are all low.
- R2: A push accepted while idle lowers the pointer by two in the next cycle. Then, on two consecutive cycles, it writes the low data byte at the new pointer and the high data byte at the pointer plus one.
- R3: A pop issues a byte read at the pointer and then a byte read at the pointer plus one. It returns the word with bits 7:0 taken from the lower address and bits 15:8 from the higher one, and it raises the pointer by two when the word is delivered.
- R4: The memory address is (segment × 16 + pointer offset) modulo 2^20. The segment is sampled when the command is accepted.
- R5: Words come back in last-in, first-out order.
- R6: Pointer arithmetic wraps modulo 65536 and never carries into the segment. A pop at FFFEh leaves 0000h, and a push at 0000h leaves FFFEh.
- R7: Push and pop together in one idle cycle cause a one-cycle error pulse in the next cycle. No memory access is made and the pointer does not change.
- R8: Busy is high from the cycle after a command is accepted until the last byte transfer completes. Commands that arrive while busy are ignored, and a read strobe and a write strobe never occur together.
- R9: Done pulses for exactly one cycle, with busy low, right after the final transfer. The returned word changes only when a pop completes.
- R10: A pop waits any number of cycles for the read-valid strobe of each byte before it moves on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| seg_i | input | 16 | Stack segment value |
| push_i | input | 1 | Push command |
| pop_i | input | 1 | Pop command |
| wdata_i | input | 16 | Word to push |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Conflicting-command pulse |
| rdata_o | output | 16 | Last popped word |
| sp_o | output | 16 | Current stack pointer offset |
| mem_addr_o | output | 20 | Byte address |
| mem_wr_o | output | 1 | Byte write strobe |
| mem_rd_o | output | 1 | Byte read request |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Returned read byte |
| mem_rvalid_i | input | 1 | Read byte valid |

## Verification
A pointer that moves by a wrong amount, or at the wrong time, shows up on the address lines at the very next byte transfer. It also shows on the pointer output in the cycle after the command is accepted. A corrupted lane choice or a swapped read assembly does not show until the matching pop, when the word comes back with its bytes reversed or mixed. The bench therefore pairs every pop with a reference stack and also inspects the memory bytes right after each push. A sequencer stuck in a non-idle state keeps busy high, so the next command never gets a completion strobe.

// File: rtl/wstack_pkg.sv
package wstack_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_LO,
      ST_WR_HI,
      ST_RD_LO,
      ST_WT_LO,
      ST_RD_HI,
      ST_WT_HI
   } stk_state_e;
endpackage

// File: rtl/wstack_ptr.sv
module wstack_ptr #(
   parameter int SP_W = 16,
   parameter logic [SP_W-1:0] SP_RESET = 16'hFFFE,
   parameter int STEP = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dec_i,
   input  logic            inc_i,
   output logic [SP_W-1:0] sp_o
);
   localparam logic [SP_W-1:0] STEP_V = SP_W'(STEP);

   logic [SP_W-1:0] sp_q;

   // wraps naturally at SP_W bits; nothing carries out
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sp_q <= SP_RESET;
      else if (dec_i) sp_q <= sp_q - STEP_V;
      else if (inc_i) sp_q <= sp_q + STEP_V;
   end

   assign sp_o = sp_q;
endmodule

// File: rtl/wstack_addr.sv
module wstack_addr #(
   parameter int SEG_W     = 16,
   parameter int SP_W      = 16,
   parameter int SEG_SHIFT = 4,
   parameter int PA_W      = 20
) (
   input  logic [SEG_W-1:0] seg_i,
   input  logic [SP_W-1:0]  sp_i,
   input  logic             hi_sel_i,
   output logic [PA_W-1:0]  pa_o
);
   logic [SP_W-1:0] off;
   logic [PA_W-1:0] base;

   // byte offset stays inside the segment
   assign off = sp_i + SP_W'(hi_sel_i);

   generate
      if (SEG_SHIFT == 0) begin : g_flat
         assign base = PA_W'(seg_i);
      end else begin : g_shifted
         assign base = PA_W'({seg_i, {SEG_SHIFT{1'b0}}});
      end
   endgenerate

   assign pa_o = base + PA_W'(off);
endmodule

// File: rtl/wstack_seq.sv
module wstack_seq
   import wstack_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 2,
   parameter int SEG_W  = 16,
   localparam int WORD_W = BYTE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic [SEG_W-1:0]  seg_i,
   input  logic [BYTE_W-1:0] mem_rdata_i,
   input  logic              mem_rvalid_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [WORD_W-1:0] rdata_o,
   output logic [SEG_W-1:0]  seg_o,
   output logic              dec_o,
   output logic              inc_o,
   output logic              hi_sel_o,
   output logic              mem_wr_o,
   output logic              mem_rd_o,
   output logic [BYTE_W-1:0] mem_wdata_o
);
   stk_state_e        state_q;
   logic [WORD_W-1:0] wbuf_q;
   logic [BYTE_W-1:0] lo_q;
   logic [WORD_W-1:0] rdata_q;
   logic [SEG_W-1:0]  seg_q;
   logic              done_q, err_q;
   logic              idle, take_push, take_pop, clash;
   logic [BYTE_W-1:0] lane [LANES];

   assign idle      = (state_q == ST_IDLE);
   assign take_push = idle && push_i && !pop_i;
   assign take_pop  = idle && pop_i && !push_i;
   assign clash     = idle && push_i && pop_i;

   // little-endian lane split: lane 0 is the low-order byte
   generate
      for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
         assign lane[gi] = wbuf_q[gi*BYTE_W +: BYTE_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wbuf_q  <= '0;
         lo_q    <= '0;
         rdata_q <= '0;
         seg_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= clash;
         case (state_q)
            ST_IDLE: begin
               if (take_push) begin
                  wbuf_q  <= wdata_i;
                  seg_q   <= seg_i;
                  state_q <= ST_WR_LO;
               end else if (take_pop) begin
                  seg_q   <= seg_i;
                  state_q <= ST_RD_LO;
               end
            end
            ST_WR_LO: state_q <= ST_WR_HI;
            ST_WR_HI: begin
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            ST_RD_LO: state_q <= ST_WT_LO;
            ST_WT_LO: begin
               if (mem_rvalid_i) begin
                  lo_q    <= mem_rdata_i;
                  state_q <= ST_RD_HI;
               end
            end
            ST_RD_HI: state_q <= ST_WT_HI;
            ST_WT_HI: begin
               if (mem_rvalid_i) begin
                  rdata_q <= {mem_rdata_i, lo_q};
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o      = !idle;
   assign done_o      = done_q;
   assign err_o       = err_q;
   assign rdata_o     = rdata_q;
   assign seg_o       = seg_q;
   assign dec_o       = take_push;
   assign inc_o       = (state_q == ST_WT_HI) && mem_rvalid_i;
   assign hi_sel_o    = (state_q == ST_WR_HI) || (state_q == ST_RD_HI) ||
                        (state_q == ST_WT_HI);
   assign mem_wr_o    = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
   assign mem_rd_o    = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
   assign mem_wdata_o = (state_q == ST_WR_HI) ? lane[1] : lane[0];
endmodule

// File: rtl/wstack_unit.sv
module wstack_unit #(
   parameter int BYTE_W    = 8,
   parameter int LANES     = 2,
   parameter int SEG_W     = 16,
   parameter int SP_W      = 16,
   parameter int SEG_SHIFT = 4,
   parameter logic [SP_W-1:0] SP_RESET = 16'hFFFE,
   localparam int WORD_W = BYTE_W * LANES,
   localparam int PA_W   = SEG_W + SEG_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEG_W-1:0]  seg_i,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [WORD_W-1:0] rdata_o,
   output logic [SP_W-1:0]   sp_o,
   output logic [PA_W-1:0]   mem_addr_o,
   output logic              mem_wr_o,
   output logic              mem_rd_o,
   output logic [BYTE_W-1:0] mem_wdata_o,
   input  logic [BYTE_W-1:0] mem_rdata_i,
   input  logic              mem_rvalid_i
);
   generate
      if (LANES != 2) begin : g_bad_lanes
         $error("wstack_unit: LANES must be 2");
      end
      if (SP_W > PA_W) begin : g_bad_width
         $error("wstack_unit: SP_W exceeds physical address width");
      end
      if (SP_RESET[0] != 1'b0) begin : g_bad_reset
         $error("wstack_unit: SP_RESET must be word aligned");
      end
   endgenerate

   logic             dec, inc, hi_sel;
   logic [SEG_W-1:0] seg_q;

   wstack_seq #(.BYTE_W(BYTE_W), .LANES(LANES), .SEG_W(SEG_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .push_i(push_i), .pop_i(pop_i), .wdata_i(wdata_i), .seg_i(seg_i),
      .mem_rdata_i(mem_rdata_i), .mem_rvalid_i(mem_rvalid_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
      .seg_o(seg_q), .dec_o(dec), .inc_o(inc), .hi_sel_o(hi_sel),
      .mem_wr_o(mem_wr_o), .mem_rd_o(mem_rd_o), .mem_wdata_o(mem_wdata_o)
   );

   wstack_ptr #(.SP_W(SP_W), .SP_RESET(SP_RESET), .STEP(LANES)) u_ptr (
      .clk(clk), .rst_n(rst_n), .dec_i(dec), .inc_i(inc), .sp_o(sp_o)
   );

   wstack_addr #(.SEG_W(SEG_W), .SP_W(SP_W), .SEG_SHIFT(SEG_SHIFT),
                 .PA_W(PA_W)) u_addr (
      .seg_i(seg_q), .sp_i(sp_o), .hi_sel_i(hi_sel), .pa_o(mem_addr_o)
   );
endmodule

// File: rtl/wstack_chk.sv
module wstack_chk #(
   parameter int SP_W  = 16,
   parameter int PA_W  = 20,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_i,
   input logic              pop_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic [WORD_W-1:0] rdata_o,
   input logic [SP_W-1:0]   sp_o,
   input logic [PA_W-1:0]   mem_addr_o,
   input logic              mem_wr_o,
   input logic              mem_rd_o
);
   assert_sp_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sp_o[0] == 1'b0);

   assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && push_i && !pop_i) |=> (sp_o == $past(sp_o) - SP_W'(2)));

   assert_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && push_i && pop_i) |=> (err_o && !busy_o && $stable(sp_o)));

   assert_wr_lo_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_o && !$past(mem_wr_o)) |-> !mem_addr_o[0]);

   assert_wr_hi_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_o && $past(mem_wr_o)) |->
         (mem_addr_o[0] && mem_addr_o[PA_W-1:1] == $past(mem_addr_o[PA_W-1:1])));

   assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr_o && mem_rd_o));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(rdata_o));
endmodule

bind wstack_unit wstack_chk #(.SP_W(SP_W), .PA_W(PA_W), .WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
   .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
   .sp_o(sp_o), .mem_addr_o(mem_addr_o), .mem_wr_o(mem_wr_o),
   .mem_rd_o(mem_rd_o)
);

// File: tb/wstack_unit_test.sv
module wstack_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] seg_i = '0;
   logic        push_i = 1'b0, pop_i = 1'b0;
   logic [15:0] wdata_i = '0;
   logic        busy_o, done_o, err_o;
   logic [15:0] rdata_o, sp_o;
   logic [19:0] mem_addr_o;
   logic        mem_wr_o, mem_rd_o;
   logic [7:0]  mem_wdata_o;
   logic [7:0]  mem_rdata_i = '0;
   logic        mem_rvalid_i = 1'b0;

   always #2 clk = ~clk;

   wstack_unit uut (
      .clk(clk), .rst_n(rst_n), .seg_i(seg_i), .push_i(push_i), .pop_i(pop_i),
      .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
      .rdata_o(rdata_o), .sp_o(sp_o), .mem_addr_o(mem_addr_o),
      .mem_wr_o(mem_wr_o), .mem_rd_o(mem_rd_o), .mem_wdata_o(mem_wdata_o),
      .mem_rdata_i(mem_rdata_i), .mem_rvalid_i(mem_rvalid_i)
   );

   int checks = 0, errors = 0;
   bit finished = 0;

   // ---------------- memory model ----------------
   logic [7:0]  mem [int];
   int          wr_cnt = 0, rd_cnt = 0;
   logic [19:0] wlog [2];
   logic [19:0] rlog [2];
   bit          pend = 0;
   int          pcnt = 0;
   logic [19:0] paddr = '0;

   function automatic logic [7:0] mrd(logic [19:0] a);
      return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
   endfunction

   function automatic logic [19:0] phys(logic [15:0] s, logic [15:0] p);
      return {s, 4'h0} + {4'h0, p};
   endfunction

   always @(negedge clk) begin
      mem_rvalid_i = 1'b0;
      if (mem_wr_o) begin
         mem[int'(mem_addr_o)] = mem_wdata_o;
         wlog[0] = wlog[1]; wlog[1] = mem_addr_o;
         wr_cnt++;
      end
      if (pend) begin
         if (pcnt == 0) begin
            mem_rvalid_i = 1'b1;
            mem_rdata_i  = mrd(paddr);
            pend = 0;
         end else pcnt--;
      end
      if (mem_rd_o) begin
         pend = 1; paddr = mem_addr_o; pcnt = $urandom % 4;
         rlog[0] = rlog[1]; rlog[1] = mem_addr_o;
         rd_cnt++;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   logic [15:0] exp_sp = 16'hFFFE;
   logic [15:0] q [$];

   task automatic wait_done(string req);
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (done_o) return;
      end
      chk(0, req, 0, 1);
   endtask

   task automatic do_push(logic [15:0] w, bit poke_busy);
      logic [19:0] a;
      int w0;
      w0 = wr_cnt;
      @(negedge clk);
      push_i = 1; wdata_i = w;
      @(negedge clk);
      push_i = 0;
      exp_sp = exp_sp - 16'd2;
      chk(busy_o == 1'b1, "R8 busy after push", busy_o, 1);
      chk(sp_o == exp_sp, "R2 sp after push", sp_o, exp_sp);
      if (poke_busy) begin
         pop_i = 1; push_i = 1; wdata_i = ~w;
         @(negedge clk);
         pop_i = 0; push_i = 0;
      end
      wait_done("R9 push done");
      a = phys(seg_i, exp_sp);
      chk(busy_o == 1'b0, "R9 idle with done", busy_o, 0);
      chk(wr_cnt - w0 == 2, "R8 two writes", wr_cnt - w0, 2);
      chk(wlog[0] == a && wlog[1] == a + 20'd1, "R2 write order", wlog[0], a);
      chk({mrd(a + 20'd1), mrd(a)} == w, "R4 stored bytes", {mrd(a + 20'd1), mrd(a)}, w);
      chk(sp_o == exp_sp, "R8 sp unchanged by busy cmds", sp_o, exp_sp);
      q.push_back(w);
      @(negedge clk);
      chk(done_o == 1'b0 && busy_o == 1'b0, "R9 done one cycle", {done_o, busy_o}, 0);
   endtask

   task automatic do_pop();
      logic [15:0] exp_w, prev;
      logic [19:0] a;
      bit held;
      a = phys(seg_i, exp_sp);
      if (q.size() > 0) exp_w = q.pop_back();
      else exp_w = {mrd(a + 20'd1), mrd(a)};
      prev = rdata_o;
      held = 1;
      @(negedge clk);
      pop_i = 1;
      @(negedge clk);
      pop_i = 0;
      for (int i = 0; i < 60; i++) begin
         if (done_o) break;
         if (rdata_o != prev || sp_o != exp_sp) held = 0;
         @(negedge clk);
      end
      chk(held, "R9 rdata held during pop", rdata_o, prev);
      chk(done_o == 1'b1, "R10 pop completes", done_o, 1);
      exp_sp = exp_sp + 16'd2;
      chk(rlog[0] == a && rlog[1] == a + 20'd1, "R3 read order", rlog[0], a);
      chk(rdata_o == exp_w, "R5 popped word", rdata_o, exp_w);
      chk(sp_o == exp_sp, "R3 sp after pop", sp_o, exp_sp);
   endtask

   initial begin
      logic [15:0] s0;
      int w0, r0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(sp_o == 16'hFFFE, "R1 sp reset", sp_o, 16'hFFFE);
      chk(!busy_o && !done_o && !err_o, "R1 flags reset", {busy_o, done_o, err_o}, 0);

      // R6 wrap on pop from FFFE, R3 little-endian assembly
      seg_i = 16'h0100;
      mem[int'(20'h10FFE)] = 8'h34;
      mem[int'(20'h10FFF)] = 8'h12;
      do_pop();
      chk(rdata_o == 16'h1234, "R3 low byte at low address", rdata_o, 16'h1234);
      chk(sp_o == 16'h0000, "R6 pop wraps to 0000", sp_o, 16'h0000);
      do_push(16'hA5C3, 0);
      chk(sp_o == 16'hFFFE, "R6 push wraps to FFFE", sp_o, 16'hFFFE);
      chk(mrd(20'h10FFE) == 8'hC3 && mrd(20'h10FFF) == 8'hA5, "R2 lanes", mrd(20'h10FFE), 8'hC3);
      do_pop();

      // R7 conflicting commands
      do_push(16'h5555, 0);
      s0 = sp_o; w0 = wr_cnt; r0 = rd_cnt;
      push_i = 1; pop_i = 1; wdata_i = 16'hDEAD;
      @(negedge clk);
      push_i = 0; pop_i = 0;
      chk(err_o == 1'b1, "R7 err pulse", err_o, 1);
      chk(!busy_o && sp_o == s0, "R7 state unchanged", sp_o, s0);
      @(negedge clk);
      chk(err_o == 1'b0, "R7 err one cycle", err_o, 0);
      repeat (3) @(negedge clk);
      chk(wr_cnt == w0 && rd_cnt == r0, "R7 no memory access", wr_cnt, w0);
      do_pop();

      // R4 physical address wraps at 20 bits
      seg_i = 16'hFFFF;
      do_push(16'hBEEF, 0);
      chk(mrd(phys(16'hFFFF, exp_sp)) == 8'hEF, "R4 20-bit wrap", mrd(phys(16'hFFFF, exp_sp)), 8'hEF);
      do_pop();

      // R8 commands while busy are ignored
      seg_i = 16'h2000;
      do_push(16'h0F0F, 1);
      do_pop();

      // random LIFO traffic
      for (int n = 0; n < 400; n++) begin
         if (q.size() == 0 || ($urandom % 10) < 6) do_push(16'($urandom), 0);
         else do_pop();
      end
      while (q.size() > 0) do_pop();

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule